// File: doc/BRIEF.md
# Processor control register file

This block keeps the control registers of a 32-bit processor core. These are the status byte and its backup byte, a second-level backup status byte, the condition flag, two backup program counters, two scratch words, and a pair of stack-pointer shadows. One of those shadows is banked against the live stack pointer that the general register file also uses. A combinational read port and a clocked write port both select a register by a 4-bit control index.

The live stack pointer is driven out on its own port and can be loaded through a separate write path, so the general register file does not keep a second copy. A stack-mode flag (status bit 7) decides which logical stack register is live at any moment. When a status write flips that flag, the live value and the matching shadow are exchanged in the same clock cycle.

Control index map (fixed): 0 status, 1 condition flag, 2 interrupt stack, 3 user stack, 4 and 5 scratch, 6 first backup PC, 7 second backup PC, 8 second-level backup status, 9 to 15 unused.

Top module: `ctrl_regbank`

## Requirements
- R1: After reset every control index reads 0, the stack-mode flag and condition flag are 0, and `sp_live` is 0.
- R2: A read of index 0 returns bits 15:8 equal to the backup byte ANDed with 0xC1, bits 7:6 equal to status bits 7:6, bit 0 equal to the condition flag, and every other bit 0.
- R3: A write to index 0 loads data bits 15:8 into the backup byte and bits 7:0 into the status byte, and sets the condition flag from data bit 0, from the next rising edge on.
- R4: A status write that clears a set stack-mode flag (bit 7, 1 to 0) moves the live pointer into the user-stack shadow and loads the live pointer from the interrupt-stack shadow.
- R5: A status write that sets a clear stack-mode flag (0 to 1) moves the live pointer into the interrupt-stack shadow and loads the live pointer from the user-stack shadow. A status write that leaves the flag unchanged moves no pointer.
- R6: With the stack-mode flag at 0, index 2 reads and writes the live pointer and index 3 reads and writes the user-stack shadow. With the flag at 1, index 3 is live and index 2 is the interrupt-stack shadow.
- R7: Index 8 stores the low 8 bits of a write and reads back that byte ANDed with 0xC1.
- R8: Index 1 reads back the condition flag in bit 0, with all other bits 0, and a write to it sets the flag from data bit 0 and changes no other status bit.
- R9: Indices 6 and 7 store all 32 written bits and read back with bit 0 forced to 0.
- R10: Indices 4 and 5 store and return full 32-bit words. Indices 9 to 15 read as 0, and writes to them change no register.
- R11: When `sp_wr_en` is high, `sp_live` takes `sp_wr_data` at the next edge. A stack swap caused by a status write in the same cycle overrides it.
- R12: A control-port write to the live stack register in the same cycle as `sp_wr_en` wins over the stack-pointer port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_idx | input | 4 | Control index for the combinational read |
| rd_data | output | 32 | Read value for `rd_idx` |
| wr_en | input | 1 | Control-port write enable |
| wr_idx | input | 4 | Control index for the write |
| wr_data | input | 32 | Control-port write value |
| sp_live | output | 32 | Live stack pointer value |
| sp_wr_en | input | 1 | Stack-pointer port write enable |
| sp_wr_data | input | 32 | Stack-pointer port write value |

## Verification
The stack swap is exercised in both directions from known, distinct pointer values. A status write that keeps the mode unchanged is also applied, so an exchange that happens on every status write is caught as well as one that is missing. Status words use different bit patterns in the masked and unmasked positions, so a wrong mask, a dropped condition flag or a swapped byte each produce a different read value. Same-cycle collisions are driven on purpose: a status swap together with a stack-port write, and a control write to the live register together with a stack-port write. These collisions separate the two priority rules. Every unused index is written with all ones and then read back, alongside the scratch words and the live pointer, to show that those writes reach no register.

// File: rtl/ctrl_regbank_pkg.sv
package ctrl_regbank_pkg;
  localparam int CR_IDX_W = 4;
  localparam logic [CR_IDX_W-1:0] CR_STATUS   = 4'd0;
  localparam logic [CR_IDX_W-1:0] CR_COND     = 4'd1;
  localparam logic [CR_IDX_W-1:0] CR_ISTACK   = 4'd2;
  localparam logic [CR_IDX_W-1:0] CR_USTACK   = 4'd3;
  localparam logic [CR_IDX_W-1:0] CR_SCR_BASE = 4'd4;
  localparam int                  CR_NUM_SCR  = 2;
  localparam logic [CR_IDX_W-1:0] CR_BPC0     = 4'd6;
  localparam logic [CR_IDX_W-1:0] CR_BPC1     = 4'd7;
  localparam logic [CR_IDX_W-1:0] CR_BBSTAT   = 4'd8;
  localparam logic [7:0]          BKUP_MASK   = 8'hC1;
  localparam logic [7:0]          STAT_MASK   = 8'hC0;
endpackage

// File: rtl/crb_rst_sync.sv
module crb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/crb_status.sv
module crb_status
  import ctrl_regbank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_status,
  input  logic              wr_cond,
  input  logic              wr_bbstat,
  input  logic [15:0]       wd,
  output logic              stack_mode,
  output logic              swap_up,
  output logic              swap_dn,
  output logic [DATA_W-1:0] status_view,
  output logic [DATA_W-1:0] cond_view,
  output logic [DATA_W-1:0] bbstat_view
);
  localparam int PAD_W = DATA_W - 16;

  logic [7:0] bk_q, bk_d;
  logic [7:0] st_q, st_d;
  logic [7:0] bb_q, bb_d;
  logic       cond_q, cond_d;

  always_comb begin
    bk_d   = bk_q;
    st_d   = st_q;
    bb_d   = bb_q;
    cond_d = cond_q;
    if (wr_status) begin
      bk_d   = wd[15:8];
      st_d   = wd[7:0];
      cond_d = wd[0];
    end
    if (wr_cond)   cond_d = wd[0];
    if (wr_bbstat) bb_d   = wd[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bk_q   <= '0;
      st_q   <= '0;
      bb_q   <= '0;
      cond_q <= 1'b0;
    end else begin
      bk_q   <= bk_d;
      st_q   <= st_d;
      bb_q   <= bb_d;
      cond_q <= cond_d;
    end
  end

  assign stack_mode  = st_q[7];
  assign swap_up     = wr_status &  wd[7] & ~st_q[7];
  assign swap_dn     = wr_status & ~wd[7] &  st_q[7];
  assign status_view = {{PAD_W{1'b0}}, bk_q & BKUP_MASK, (st_q & STAT_MASK) | {7'd0, cond_q}};
  assign cond_view   = {{(DATA_W-1){1'b0}}, cond_q};
  assign bbstat_view = {{(DATA_W-8){1'b0}}, bb_q & BKUP_MASK};

  // R3
  status_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_status |=> status_view[15:0] ==
      {$past(wd[15:8]) & BKUP_MASK, $past(wd[7:6]), 5'd0, $past(wd[0])});

  // R8
  cond_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cond && !wr_status) |=> (cond_view[0] == $past(wd[0])) && $stable(status_view[15:1]));
endmodule

// File: rtl/crb_stack.sv
module crb_stack #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stack_mode,
  input  logic              swap_up,
  input  logic              swap_dn,
  input  logic              wr_istack,
  input  logic              wr_ustack,
  input  logic [DATA_W-1:0] wd,
  input  logic              sp_wr_en,
  input  logic [DATA_W-1:0] sp_wr_data,
  output logic [DATA_W-1:0] sp_live,
  output logic [DATA_W-1:0] istack_view,
  output logic [DATA_W-1:0] ustack_view
);
  logic [DATA_W-1:0] live_q, live_d;
  logic [DATA_W-1:0] ish_q, ish_d;
  logic [DATA_W-1:0] ush_q, ush_d;

  always_comb begin
    live_d = live_q;
    ish_d  = ish_q;
    ush_d  = ush_q;
    if (sp_wr_en) live_d = sp_wr_data;
    if (swap_up) begin
      ish_d  = live_q;
      live_d = ush_q;
    end else if (swap_dn) begin
      ush_d  = live_q;
      live_d = ish_q;
    end else begin
      if (wr_istack) begin
        if (stack_mode) ish_d  = wd;
        else            live_d = wd;
      end
      if (wr_ustack) begin
        if (stack_mode) live_d = wd;
        else            ush_d  = wd;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
      ish_q  <= '0;
      ush_q  <= '0;
    end else begin
      live_q <= live_d;
      ish_q  <= ish_d;
      ush_q  <= ush_d;
    end
  end

  assign sp_live     = live_q;
  assign istack_view = stack_mode ? ish_q  : live_q;
  assign ustack_view = stack_mode ? live_q : ush_q;

  // R4
  swap_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap_dn |=> (sp_live == $past(ish_q)) && (ush_q == $past(sp_live)));

  // R5
  swap_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap_up |=> (sp_live == $past(ush_q)) && (ish_q == $past(sp_live)));

  // R11
  sp_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_wr_en && !swap_up && !swap_dn && !wr_istack && !wr_ustack)
      |=> sp_live == $past(sp_wr_data));

  // R12
  cr_over_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_wr_en && wr_istack && !stack_mode && !swap_up && !swap_dn) |=> sp_live == $past(wd));
endmodule

// File: rtl/crb_word.sv
module crb_word #(
  parameter int DATA_W  = 32,
  parameter bit CLR_LSB = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wd,
  output logic [DATA_W-1:0] view
);
  logic [DATA_W-1:0] q, d;

  always_comb d = wr_en ? wd : q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

  generate
    if (CLR_LSB) begin : g_clr
      assign view = q & ~{{(DATA_W-1){1'b0}}, 1'b1};
    end else begin : g_full
      assign view = q;
    end
  endgenerate
endmodule

// File: rtl/ctrl_regbank.sv
module ctrl_regbank
  import ctrl_regbank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CR_IDX_W-1:0] rd_idx,
  output logic [DATA_W-1:0]   rd_data,
  input  logic                wr_en,
  input  logic [CR_IDX_W-1:0] wr_idx,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [DATA_W-1:0]   sp_live,
  input  logic                sp_wr_en,
  input  logic [DATA_W-1:0]   sp_wr_data
);
  logic              rst_n_s;
  logic              stack_mode, swap_up, swap_dn;
  logic [DATA_W-1:0] status_view, cond_view, bbstat_view;
  logic [DATA_W-1:0] istack_view, ustack_view;
  logic [DATA_W-1:0] bpc0_view, bpc1_view;
  logic [DATA_W-1:0] scr_view [CR_NUM_SCR];
  logic              wr_known;

  crb_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  crb_status #(.DATA_W(DATA_W)) u_status (
    .clk(clk), .rst_n(rst_n_s),
    .wr_status(wr_en && wr_idx == CR_STATUS),
    .wr_cond  (wr_en && wr_idx == CR_COND),
    .wr_bbstat(wr_en && wr_idx == CR_BBSTAT),
    .wd(wr_data[15:0]),
    .stack_mode(stack_mode), .swap_up(swap_up), .swap_dn(swap_dn),
    .status_view(status_view), .cond_view(cond_view), .bbstat_view(bbstat_view)
  );

  crb_stack #(.DATA_W(DATA_W)) u_stack (
    .clk(clk), .rst_n(rst_n_s),
    .stack_mode(stack_mode), .swap_up(swap_up), .swap_dn(swap_dn),
    .wr_istack(wr_en && wr_idx == CR_ISTACK),
    .wr_ustack(wr_en && wr_idx == CR_USTACK),
    .wd(wr_data), .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data),
    .sp_live(sp_live), .istack_view(istack_view), .ustack_view(ustack_view)
  );

  crb_word #(.DATA_W(DATA_W), .CLR_LSB(1'b1)) u_bpc0 (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en && wr_idx == CR_BPC0),
    .wd(wr_data), .view(bpc0_view));

  crb_word #(.DATA_W(DATA_W), .CLR_LSB(1'b1)) u_bpc1 (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en && wr_idx == CR_BPC1),
    .wd(wr_data), .view(bpc1_view));

  generate
    for (genvar i = 0; i < CR_NUM_SCR; i++) begin : g_scr
      localparam logic [CR_IDX_W-1:0] MY_IDX = CR_SCR_BASE + CR_IDX_W'(i);
      crb_word #(.DATA_W(DATA_W), .CLR_LSB(1'b0)) u_scr (
        .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en && wr_idx == MY_IDX),
        .wd(wr_data), .view(scr_view[i]));
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    case (rd_idx)
      CR_STATUS: rd_data = status_view;
      CR_COND:   rd_data = cond_view;
      CR_ISTACK: rd_data = istack_view;
      CR_USTACK: rd_data = ustack_view;
      CR_BPC0:   rd_data = bpc0_view;
      CR_BPC1:   rd_data = bpc1_view;
      CR_BBSTAT: rd_data = bbstat_view;
      default: begin
        for (int i = 0; i < CR_NUM_SCR; i++)
          if (rd_idx == CR_SCR_BASE + CR_IDX_W'(i)) rd_data = scr_view[i];
      end
    endcase
  end

  assign wr_known = (wr_idx <= CR_BBSTAT);

  // R10
  undef_write_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_en && !wr_known && !sp_wr_en) |=>
      $stable(sp_live) && $stable(status_view) && $stable(bbstat_view) &&
      $stable(bpc0_view) && $stable(bpc1_view));

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n_s |-> (sp_live == '0) && (status_view == '0));
endmodule

// File: tb/ctrl_regbank_bench.sv
module ctrl_regbank_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  rd_idx, wr_idx;
  logic [31:0] rd_data, wr_data, sp_live, sp_wr_data;
  logic        wr_en, sp_wr_en;
  int          checks = 0;
  int          errors = 0;

  ctrl_regbank u_ctrl_regbank (
    .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_data(rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .sp_live(sp_live), .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] idx, input logic [31:0] exp);
    rd_idx = idx;
    #1;
    check(tag, rd_data, exp);
  endtask

  // inputs change at negedge; one write commits at the following posedge
  task automatic cr_wr(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic sp_wr(input logic [31:0] d);
    @(negedge clk);
    sp_wr_en = 1'b1; sp_wr_data = d;
    @(negedge clk);
    sp_wr_en = 1'b0;
  endtask

  task automatic both_wr(input logic [3:0] idx, input logic [31:0] d, input logic [31:0] spd);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    sp_wr_en = 1'b1; sp_wr_data = spd;
    @(negedge clk);
    wr_en = 1'b0; sp_wr_en = 1'b0;
  endtask

  task automatic t_reset();
    for (int i = 0; i < 16; i++) rd_chk("R1 reset read", 4'(i), 32'h0);
    check("R1 reset sp_live", sp_live, 32'h0);
  endtask

  task automatic t_status();
    cr_wr(4'd0, 32'hFFFF_ABCD);
    rd_chk("R2/R3 status view", 4'd0, 32'h0000_81C1);
    rd_chk("R3 cond from status", 4'd1, 32'h1);
    cr_wr(4'd0, 32'h0000_3E3E);
    rd_chk("R2 masked bits", 4'd0, 32'h0000_0000);
    cr_wr(4'd0, 32'h0000_C141);
    rd_chk("R2 status view 2", 4'd0, 32'h0000_C141);
    cr_wr(4'd1, 32'hFFFF_FFFE);
    rd_chk("R8 cond cleared", 4'd1, 32'h0);
    rd_chk("R8 status kept", 4'd0, 32'h0000_C140);
    cr_wr(4'd1, 32'h0000_0001);
    rd_chk("R8 cond set", 4'd1, 32'h1);
    cr_wr(4'd0, 32'h0);
  endtask

  task automatic t_swap();
    sp_wr(32'h1111_0000);
    check("R11 sp port", sp_live, 32'h1111_0000);
    rd_chk("R6 mode0 istack live", 4'd2, 32'h1111_0000);
    cr_wr(4'd3, 32'h2222_0000);
    rd_chk("R6 mode0 ustack shadow", 4'd3, 32'h2222_0000);
    check("R6 live untouched", sp_live, 32'h1111_0000);
    cr_wr(4'd0, 32'h0000_0080);
    check("R5 swap up live", sp_live, 32'h2222_0000);
    rd_chk("R5 istack shadow", 4'd2, 32'h1111_0000);
    rd_chk("R6 mode1 ustack live", 4'd3, 32'h2222_0000);
    cr_wr(4'd0, 32'h0000_00C0);
    check("R5 no swap same mode", sp_live, 32'h2222_0000);
    cr_wr(4'd2, 32'h5555_0000);
    check("R6 mode1 istack shadow write", sp_live, 32'h2222_0000);
    cr_wr(4'd0, 32'h0000_0000);
    check("R4 swap down live", sp_live, 32'h5555_0000);
    rd_chk("R4 ustack shadow", 4'd3, 32'h2222_0000);
  endtask

  task automatic t_priority();
    // mode 0: live 5555_0000, user shadow 2222_0000
    both_wr(4'd0, 32'h0000_0080, 32'hDEAD_0000);
    check("R11 swap beats sp port", sp_live, 32'h2222_0000);
    rd_chk("R11 istack got old live", 4'd2, 32'h5555_0000);
    both_wr(4'd3, 32'h3333_0000, 32'h4444_0000);
    check("R12 cr write beats sp port", sp_live, 32'h3333_0000);
    cr_wr(4'd0, 32'h0);
  endtask

  task automatic t_words();
    cr_wr(4'd8, 32'hFFFF_FFFF);
    rd_chk("R7 bbstat mask", 4'd8, 32'h0000_00C1);
    cr_wr(4'd8, 32'h0000_003E);
    rd_chk("R7 bbstat masked off", 4'd8, 32'h0);
    cr_wr(4'd6, 32'hFFFF_FFFF);
    rd_chk("R9 bpc0 lsb", 4'd6, 32'hFFFF_FFFE);
    cr_wr(4'd7, 32'h1234_5679);
    rd_chk("R9 bpc1 lsb", 4'd7, 32'h1234_5678);
    cr_wr(4'd4, 32'hA5A5_A5A5);
    cr_wr(4'd5, 32'h5A5A_5A5B);
    rd_chk("R10 scratch4", 4'd4, 32'hA5A5_A5A5);
    rd_chk("R10 scratch5", 4'd5, 32'h5A5A_5A5B);
  endtask

  task automatic t_undef();
    logic [31:0] sp_before;
    sp_before = sp_live;
    for (int i = 9; i < 16; i++) cr_wr(4'(i), 32'hFFFF_FFFF);
    for (int i = 9; i < 16; i++) rd_chk("R10 undefined reads zero", 4'(i), 32'h0);
    rd_chk("R10 scratch4 kept", 4'd4, 32'hA5A5_A5A5);
    rd_chk("R10 status kept", 4'd0, 32'h0);
    rd_chk("R10 bbstat kept", 4'd8, 32'h0);
    rd_chk("R10 bpc0 kept", 4'd6, 32'hFFFF_FFFE);
    check("R10 sp kept", sp_live, sp_before);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_data = '0;
    sp_wr_en = 1'b0; sp_wr_data = '0; rd_idx = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_status();
    t_swap();
    t_priority();
    t_words();
    t_undef();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule